// File: doc/BRIEF.md
# Data Bus Integrity Checker

This block protects a 32-bit data memory interface with seven check bits per word. On the write side it takes the outgoing store word and produces the check bits that travel with it, so the memory sees a 39-bit word. On the read side it recomputes the check bits from every response word and compares them with the check bits that came back. It does this for load responses and for store responses. A store response carries no useful data, but it must still carry check bits that match.

The code is a Hsiao-style single-error-correct, double-error-detect code. Every data bit owns a distinct column of weight three. After the parity is computed it is inverted with a fixed constant, so an all-zero word with all-zero check bits does not pass. When a response fails, the block does three things. It blocks the register-file write of that load at once. In the next cycle it raises a one-cycle major alert pulse. It also sets an interrupt request, which stays high until it is cleared.

A parameter turns the whole feature off. When it is off, the incoming check bits are ignored, the outgoing check bits are driven to zero, and no alert or interrupt is ever raised.

Top module: `bus_intg_guard`

## Requirements
- R1: With ENABLE=1, wr_intg_o equals the XOR, over every set bit i of wr_data_i, of column(i), then XORed with 7'h2A. column(i) is the i-th (counting from 0) 7-bit value, in ascending numeric order, that has exactly three bits set. The output is combinational, in the same cycle.
- R2: A data word of zero has check bits 7'h2A. A response with zero data and zero check bits counts as a failure.
- R3: A response with rsp_valid_i high whose check bits differ from the recomputed ones drives alert_major_o high for exactly the next cycle. A response that matches leaves alert_major_o low in the next cycle.
- R4: Flipping any one bit, or any two bits, of a valid 39-bit response word (data or check bits) is detected as a failure.
- R5: rf_we_o equals rsp_valid_i AND rsp_is_load_i AND no mismatch, in the same cycle. A failing load never writes the register file.
- R6: Store responses (rsp_is_load_i low) are checked as well. A failing store response alerts. Arbitrary store data that carries valid check bits does not alert.
- R7: While rsp_valid_i is low, the response inputs are ignored and no alert or interrupt results.
- R8: irq_o goes high in the cycle after a failing response. It stays high until a cycle in which irq_clr_i is high and no new failure arrives. A new failure takes priority over the clear.
- R9: With ENABLE=0, wr_intg_o is zero, alert_major_o and irq_o stay low, and rf_we_o equals rsp_valid_i AND rsp_is_load_i.
- R10: After a synchronous active-low reset, alert_major_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_data_i | input | 32 | Outgoing store data |
| wr_intg_o | output | 7 | Check bits for the store data |
| rsp_valid_i | input | 1 | A response word is present this cycle |
| rsp_is_load_i | input | 1 | The response belongs to a load (high) or a store (low) |
| rsp_data_i | input | 32 | Response data |
| rsp_intg_i | input | 7 | Response check bits |
| rf_we_o | output | 1 | Register-file write enable for load data |
| alert_major_o | output | 1 | One-cycle major alert pulse on a failed response |
| irq_o | output | 1 | Interrupt request, held until cleared |
| irq_clr_i | input | 1 | Clears the interrupt request |

## Verification
The block holds only two flops. If the alert flop is wrong, it shows up as a missing, doubled or stray alert_major_o pulse in the cycle right after the response. If the interrupt flop is wrong, irq_o drops early or stays high after a clear, and this is visible one cycle after the clear or the failure. Errors in the column matrix or the inversion constant show up combinationally. They appear at once on wr_intg_o, and on rf_we_o during a load response. The bench therefore checks every output in the cycle of the response and again in the cycle after it.

// File: rtl/bus_intg_pkg.sv
// Package: shared widths and the check-bit code for the data bus integrity guard.
// The code gives each data bit a distinct weight-3 column. Columns are taken
// in ascending numeric order. The parity is then XORed with INV_CONST.
package bus_intg_pkg;
    parameter int DATA_W  = 32;
    parameter int CHECK_W = 7;
    localparam int COL_WT = 3;
    localparam logic [CHECK_W-1:0] INV_CONST = 7'h2A;

    // Returns the column of data bit idx: the idx-th value with COL_WT ones.
    function automatic logic [CHECK_W-1:0] hcol(input int idx);
        int n;
        logic [CHECK_W-1:0] cand;
        n = 0;
        for (int v = 0; v < (1 << CHECK_W); v++) begin
            cand = CHECK_W'(v);
            if ($countones(cand) == COL_WT) begin
                if (n == idx) return cand;
                n++;
            end
        end
        return '0;
    endfunction

    // Returns the mask of data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] row_mask(input int j);
        logic [DATA_W-1:0]  m;
        logic [CHECK_W-1:0] c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = hcol(i);
            m[i] = c[j];
        end
        return m;
    endfunction

    // Full encoder, used by the checker module.
    function automatic logic [CHECK_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [CHECK_W-1:0] p;
        for (int j = 0; j < CHECK_W; j++) p[j] = ^(d & row_mask(j));
        return p ^ INV_CONST;
    endfunction
endpackage

// File: rtl/bus_intg_encoder.sv
// Module: produces the check bits for outgoing store data.
// Assumes: it is purely combinational. When ENABLE is 0 it drives zeros.
module bus_intg_encoder
    import bus_intg_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [CHECK_W-1:0] intg_o
);
    for (genvar j = 0; j < CHECK_W; j++) begin : g_bit
        localparam logic [DATA_W-1:0] MASK = row_mask(j);
        if (ENABLE) begin : g_on
            // Computes one parity bit and applies the inversion.
            assign intg_o[j] = (^(data_i & MASK)) ^ INV_CONST[j];
        end else begin : g_off
            assign intg_o[j] = 1'b0;
        end
    end
endmodule

// File: rtl/bus_intg_syndrome.sv
// Module: recomputes the check bits of a received word and flags a mismatch.
// Assumes: it is combinational. Any nonzero syndrome counts as a failure,
// and no correction is attempted.
module bus_intg_syndrome
    import bus_intg_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CHECK_W-1:0] intg_i,
    output logic               mismatch_o
);
    logic [CHECK_W-1:0] syn;

    for (genvar j = 0; j < CHECK_W; j++) begin : g_syn
        localparam logic [DATA_W-1:0] MASK = row_mask(j);
        // Compares one recomputed check bit with the one received.
        assign syn[j] = (^(data_i & MASK)) ^ INV_CONST[j] ^ intg_i[j];
    end

    // Reduces the syndrome to a single failure flag.
    assign mismatch_o = |syn;
endmodule

// File: rtl/bus_intg_guard.sv
// Module: the top of the integrity guard. It encodes store data and checks
// every response word. On a failure it blocks the load write-back, pulses a
// major alert and sets an interrupt request.
// Assumes: exactly one response per rsp_valid_i cycle, and synchronous
// active-low reset.
module bus_intg_guard
    import bus_intg_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [CHECK_W-1:0] wr_intg_o,
    input  logic               rsp_valid_i,
    input  logic               rsp_is_load_i,
    input  logic [DATA_W-1:0]  rsp_data_i,
    input  logic [CHECK_W-1:0] rsp_intg_i,
    output logic               rf_we_o,
    output logic               alert_major_o,
    output logic               irq_o,
    input  logic               irq_clr_i
);
    logic mismatch;
    logic rsp_bad;
    logic alert_q;
    logic irq_q;

    bus_intg_encoder #(.ENABLE(ENABLE)) u_enc (
        .data_i (wr_data_i),
        .intg_o (wr_intg_o)
    );

    if (ENABLE) begin : g_chk
        bus_intg_syndrome u_syn (
            .data_i     (rsp_data_i),
            .intg_i     (rsp_intg_i),
            .mismatch_o (mismatch)
        );
    end else begin : g_nochk
        assign mismatch = 1'b0;
    end

    // A failure only counts when a response is present.
    assign rsp_bad = rsp_valid_i & mismatch;

    // Lets a load write back only when its word passed the check.
    assign rf_we_o = rsp_valid_i & rsp_is_load_i & ~mismatch;

    // Registers the one-cycle alert pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) alert_q <= 1'b0;
        else         alert_q <= rsp_bad;
    end

    // Holds the interrupt request until it is cleared; a new failure wins.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        irq_q <= 1'b0;
        else if (rsp_bad)   irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    assign alert_major_o = alert_q;
    assign irq_o         = irq_q;
endmodule

// File: rtl/bus_intg_guard_chk.sv
// Checker: temporal properties of bus_intg_guard. It is attached with bind.
module bus_intg_guard_chk
    import bus_intg_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [CHECK_W-1:0] wr_intg_o,
    input logic               rsp_valid_i,
    input logic               rsp_is_load_i,
    input logic [DATA_W-1:0]  rsp_data_i,
    input logic [CHECK_W-1:0] rsp_intg_i,
    input logic               rf_we_o,
    input logic               alert_major_o,
    input logic               irq_o,
    input logic               irq_clr_i
);
    logic bad;
    assign bad = ENABLE && (encode(rsp_data_i) != rsp_intg_i);

    p_alert_on_fail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_i && bad |=> alert_major_o);

    p_quiet_on_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rsp_valid_i && bad) |=> !alert_major_o);

    p_block_bad_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_i && bad |-> !rf_we_o);

    p_irq_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !irq_clr_i |=> irq_o);

    p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(rsp_valid_i));

    p_off_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ENABLE |-> !alert_major_o && !irq_o && wr_intg_o == '0);
endmodule

bind bus_intg_guard bus_intg_guard_chk #(.ENABLE(ENABLE)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_data_i     (wr_data_i),
    .wr_intg_o     (wr_intg_o),
    .rsp_valid_i   (rsp_valid_i),
    .rsp_is_load_i (rsp_is_load_i),
    .rsp_data_i    (rsp_data_i),
    .rsp_intg_i    (rsp_intg_i),
    .rf_we_o       (rf_we_o),
    .alert_major_o (alert_major_o),
    .irq_o         (irq_o),
    .irq_clr_i     (irq_clr_i)
);

// File: tb/sim_bus_intg_guard.sv
module sim_bus_intg_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] wr_data;
    logic        rsp_valid, rsp_load, irq_clr;
    logic [31:0] rsp_data;
    logic [6:0]  rsp_intg;
    logic [6:0]  wr_intg, wr_intg_off;
    logic        rf_we, alert, irq;
    logic        rf_we_off, alert_off, irq_off;
    int          checks = 0;
    int          fails  = 0;
    logic        exp_irq = 1'b0;

    always #2 clk = ~clk;

    bus_intg_guard #(.ENABLE(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data), .wr_intg_o(wr_intg),
        .rsp_valid_i(rsp_valid), .rsp_is_load_i(rsp_load), .rsp_data_i(rsp_data),
        .rsp_intg_i(rsp_intg), .rf_we_o(rf_we), .alert_major_o(alert),
        .irq_o(irq), .irq_clr_i(irq_clr));

    bus_intg_guard #(.ENABLE(1'b0)) u_off (
        .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data), .wr_intg_o(wr_intg_off),
        .rsp_valid_i(rsp_valid), .rsp_is_load_i(rsp_load), .rsp_data_i(rsp_data),
        .rsp_intg_i(rsp_intg), .rf_we_o(rf_we_off), .alert_major_o(alert_off),
        .irq_o(irq_off), .irq_clr_i(irq_clr));

    // Bench model of the code as the requirements define it (R1).
    function automatic logic [6:0] ref_col(input int idx);
        int k = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(7'(v)) == 3) begin
                if (k == idx) return 7'(v);
                k++;
            end
        end
        return 7'h0;
    endfunction

    function automatic logic [6:0] ref_enc(input logic [31:0] d);
        logic [6:0] acc = 7'h0;
        for (int i = 0; i < 32; i++) if (d[i]) acc ^= ref_col(i);
        return acc ^ 7'h2A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one cycle and checks the same-cycle and next-cycle outputs.
    task automatic cyc(input bit v, input bit ld, input logic [31:0] d,
                       input logic [6:0] ig, input bit clr, input string req);
        bit bad;
        @(negedge clk);
        rsp_valid = v; rsp_load = ld; rsp_data = d; rsp_intg = ig; irq_clr = clr;
        bad = v && (ref_enc(d) != ig);
        #1;
        chk(rf_we == (v && ld && !bad), {req, " rf_we R5"}, rf_we, v && ld && !bad);
        chk(rf_we_off == (v && ld), "rf_we off R9", rf_we_off, v && ld);
        @(posedge clk);
        #1;
        if (bad) exp_irq = 1'b1;
        else if (clr) exp_irq = 1'b0;
        chk(alert == bad, {req, " alert R3"}, alert, bad);
        chk(irq == exp_irq, {req, " irq R8"}, irq, exp_irq);
        chk(!alert_off && !irq_off, "off silent R9", {alert_off, irq_off}, 0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  g;
        void'($urandom(32'h1234));
        rst_n = 1'b0; wr_data = '0; rsp_valid = 0; rsp_load = 0;
        rsp_data = '0; rsp_intg = '0; irq_clr = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(!alert && !irq, "reset R10", {alert, irq}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 and R2: the encoder on directed and random words.
        wr_data = 32'h0; #1;
        chk(wr_intg == 7'h2A, "zero word R2", wr_intg, 7'h2A);
        for (int n = 0; n < 40; n++) begin
            wr_data = (n == 0) ? 32'hFFFF_FFFF : $urandom; #1;
            chk(wr_intg == ref_enc(wr_data), "encode R1", wr_intg, ref_enc(wr_data));
            chk(wr_intg_off == 7'h0, "encode off R9", wr_intg_off, 0);
        end

        // R2: zero data with zero check bits fails.
        cyc(1, 1, 32'h0, 7'h0, 0, "zero/zero R2");
        cyc(1, 1, 32'h0, 7'h2A, 1, "zero ok R2");
        // R7: an invalid cycle with bad check bits is ignored.
        cyc(0, 1, 32'hDEAD_BEEF, 7'h0, 0, "no valid R7");
        // R6: stores are checked too.
        for (int n = 0; n < 20; n++) begin
            d = $urandom;
            cyc(1, 0, d, ref_enc(d), 0, "store ok R6");
            cyc(1, 0, d, ref_enc(d) ^ 7'h10, 0, "store bad R6");
            cyc(1, 0, d, ref_enc(d), 1, "store clr R6");
        end
        // R4: single and double flips over the full 39-bit word.
        for (int n = 0; n < 60; n++) begin
            int a, b;
            logic [38:0] w;
            d = $urandom; g = ref_enc(d);
            cyc(1, 1, d, g, n[0], "clean load R3");
            a = $urandom_range(0, 38);
            b = $urandom_range(0, 38);
            w = {g, d};
            w[a] = ~w[a];
            cyc(1, 1, w[31:0], w[38:32], 0, "single flip R4");
            if (b != a) w[b] = ~w[b];
            cyc(1, 1, w[31:0], w[38:32], 0, "double flip R4");
        end
        // R8: a failure and a clear in the same cycle keep the request set.
        cyc(1, 1, 32'h5, 7'h0, 1, "set beats clear R8");
        cyc(0, 0, 32'h0, 7'h0, 0, "hold R8");
        cyc(0, 0, 32'h0, 7'h0, 1, "clear R8");
        cyc(0, 0, 32'h0, 7'h0, 0, "stays clear R8");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule